// File: doc/BRIEF.md
# 16-bit Arithmetic Logic Unit with Double-Width Result

This block is a purely combinational arithmetic logic unit for 16-bit unsigned operands. A 4-bit operation code selects one of sixteen functions. The functions are add with carry-in, subtract with borrow-in, multiply, divide, seven bitwise logic functions, four single-position shifts and a no-operation code. The result port is 32 bits wide so that the full product of a multiply fits. Every other function leaves the upper half at zero.

A single flag output reports the carry or borrow of the add and subtract functions. It also reports the bit pushed out by the two shifts that pass through the carry, and it marks a division by zero. There is no clock and no stored state. The result follows the present operands, carry-in and operation code, so the surrounding datapath can register it wherever its timing allows.

Top module: `alu16`

## Requirements
- R1: Code 0000 drives the 17-bit sum of A, B and the carry-in. Bits 15:0 go on the result and bit 16 goes on the flag.
- R2: Code 0001 drives A minus B minus the carry-in modulo 2^16 on the result. The flag is set exactly when A is less than B plus the carry-in.
- R3: Code 0010 drives the full unsigned 32-bit product A*B, with the flag clear.
- R4: Code 0011 with a nonzero B drives the truncated unsigned quotient A/B on bits 15:0, with the flag clear.
- R5: Code 0011 with B equal to zero drives 16'hFFFF on bits 15:0 and sets the flag.
- R6: Codes 0100 to 1010 drive, in that order, A AND B, A OR B, NOT A, A XOR B, NOT(A AND B), NOT(A OR B) and NOT(A XOR B), with the flag clear.
- R7: Code 1011 shifts A left by one, and code 1100 shifts A right by one. The vacated bit is zero and the flag is clear.
- R8: Code 1101 shifts A left by one, with the carry-in entering bit 0 and A[15] on the flag. Code 1110 shifts A right by one, with the carry-in entering bit 15 and A[0] on the flag.
- R9: Code 1111 drives an all-zero result and a clear flag, whatever the operands and carry-in.
- R10: For every code except 0010, result bits 31:16 are zero.
- R11: The outputs depend only on the present inputs. A change of the operation code alone changes the outputs without any clock edge.
- R12: The carry-in has no effect on the result or flag for codes 0010 to 1100 and 1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 16 | First operand (A), and the only operand of NOT and the shifts |
| opb_i | input | 16 | Second operand (B) |
| cin_i | input | 1 | Carry-in / borrow-in and shift fill bit |
| sel_i | input | 4 | Operation code |
| res_o | output | 32 | Result, with the upper half used only by multiply |
| cout_o | output | 1 | Carry, borrow, shifted-out bit or divide-by-zero flag |

## Verification
Every operation code is applied to a set of corner operands: zero, all ones, a single top bit, a single bottom bit and equal operands. A stream of pseudo-random operand pairs follows, each pair with both carry-in values. The corners are chosen to tell results apart. A wrap at FFFF+1 separates a carry taken from bit 16 from one taken elsewhere. A borrow with equal operands separates "less than" from "less or equal". Divisors of one, of zero and larger than the dividend separate a quotient from a remainder or a saturated value. Repeating each shift and logic vector with the carry-in flipped separates the through-carry shifts from the plain ones and exposes any stray carry-in path.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int DATA_W = 16;

    // Operation codes: their numeric order is the external code map.
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_DIV  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_NOTA = 4'd6,
        OP_XOR  = 4'd7,
        OP_NAND = 4'd8,
        OP_NOR  = 4'd9,
        OP_XNOR = 4'd10,
        OP_SHL  = 4'd11,
        OP_SHR  = 4'd12,
        OP_RCL  = 4'd13,
        OP_RCR  = 4'd14,
        OP_NOP  = 4'd15
    } alu_op_e;

endpackage

// File: rtl/alu16_arith.sv
// Shared add / subtract path. The extra top bit is the carry or borrow.
module alu16_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);
    localparam int EW = W + 1;

    logic [EW-1:0] a_ext;
    logic [EW-1:0] b_ext;
    logic [EW-1:0] c_ext;
    logic [EW-1:0] total_d;

    assign a_ext = {1'b0, opa_i};
    assign b_ext = {1'b0, opb_i};
    assign c_ext = {{W{1'b0}}, cin_i};

    always_comb begin
        if (sub_i) begin
            total_d = a_ext - b_ext - c_ext;
        end else begin
            total_d = a_ext + b_ext + c_ext;
        end
    end

    assign sum_o   = total_d[W-1:0];
    assign carry_o = total_d[W];

endmodule

// File: rtl/alu16_muldiv.sv
// Shift-add multiplier and unrolled restoring divider.
module alu16_muldiv #(
    parameter int W = 16
) (
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    output logic [2*W-1:0] prod_o,
    output logic [W-1:0]   quot_o,
    output logic           divzero_o
);
    localparam int PW = 2 * W;
    localparam int RW = W + 1;

    logic [PW-1:0] a_wide;
    logic [PW-1:0] pp [W];
    logic [PW-1:0] prod_d;
    logic [RW-1:0] rem_d;
    logic [W-1:0]  quot_d;

    assign a_wide = {{W{1'b0}}, opa_i};

    // One partial product per multiplier bit.
    for (genvar g = 0; g < W; g++) begin : g_pp
        assign pp[g] = opb_i[g] ? (a_wide << g) : '0;
    end

    always_comb begin
        prod_d = '0;
        for (int i = 0; i < W; i++) begin
            prod_d = prod_d + pp[i];
        end
    end

    // Restoring division, one trial subtraction per quotient bit, MSB first.
    // A zero divisor makes every trial succeed, so the quotient is all ones.
    always_comb begin
        rem_d  = '0;
        quot_d = '0;
        for (int i = W - 1; i >= 0; i--) begin
            rem_d = {rem_d[W-1:0], opa_i[i]};
            if (rem_d >= {1'b0, opb_i}) begin
                rem_d     = rem_d - {1'b0, opb_i};
                quot_d[i] = 1'b1;
            end
        end
    end

    assign prod_o    = prod_d;
    assign quot_o    = quot_d;
    assign divzero_o = (opb_i == '0);

endmodule

// File: rtl/alu16_bitops.sv
// Bitwise logic functions and single-position shifts.
module alu16_bitops
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         cin_i,
    input  alu_op_e      op_i,
    output logic [W-1:0] res_o,
    output logic         flag_o
);
    always_comb begin
        res_o  = '0;
        flag_o = 1'b0;
        case (op_i)
            OP_AND:  res_o = opa_i & opb_i;
            OP_OR:   res_o = opa_i | opb_i;
            OP_NOTA: res_o = ~opa_i;
            OP_XOR:  res_o = opa_i ^ opb_i;
            OP_NAND: res_o = ~(opa_i & opb_i);
            OP_NOR:  res_o = ~(opa_i | opb_i);
            OP_XNOR: res_o = ~(opa_i ^ opb_i);
            OP_SHL:  res_o = {opa_i[W-2:0], 1'b0};
            OP_SHR:  res_o = {1'b0, opa_i[W-1:1]};
            OP_RCL: begin
                res_o  = {opa_i[W-2:0], cin_i};
                flag_o = opa_i[W-1];
            end
            OP_RCR: begin
                res_o  = {cin_i, opa_i[W-1:1]};
                flag_o = opa_i[0];
            end
            default: begin
                res_o  = '0;
                flag_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu16.sv
// Sixteen-function combinational ALU with a double-width result.
module alu16
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    input  logic           cin_i,
    input  logic [3:0]     sel_i,
    output logic [2*W-1:0] res_o,
    output logic           cout_o
);
    localparam int RW = 2 * W;

    typedef struct packed {
        logic          flag;
        logic [RW-1:0] res;
    } alu_out_t;

    alu_op_e       op;
    logic [W-1:0]  sum;
    logic          carry;
    logic [RW-1:0] prod;
    logic [W-1:0]  quot;
    logic          divzero;
    logic [W-1:0]  bit_res;
    logic          bit_flag;
    alu_out_t      out_d;

    assign op = alu_op_e'(sel_i);

    alu16_arith #(.W(W)) u_arith (
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .cin_i   (cin_i),
        .sub_i   (op == OP_SUB),
        .sum_o   (sum),
        .carry_o (carry)
    );

    alu16_muldiv #(.W(W)) u_muldiv (
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .prod_o    (prod),
        .quot_o    (quot),
        .divzero_o (divzero)
    );

    alu16_bitops #(.W(W)) u_bitops (
        .opa_i  (opa_i),
        .opb_i  (opb_i),
        .cin_i  (cin_i),
        .op_i   (op),
        .res_o  (bit_res),
        .flag_o (bit_flag)
    );

    // Result selection; upper half stays zero except for the product.
    always_comb begin
        out_d = '0;
        case (op)
            OP_ADD, OP_SUB: begin
                out_d.res  = {{W{1'b0}}, sum};
                out_d.flag = carry;
            end
            OP_MUL: begin
                out_d.res  = prod;
                out_d.flag = 1'b0;
            end
            OP_DIV: begin
                out_d.res  = {{W{1'b0}}, quot};
                out_d.flag = divzero;
            end
            OP_NOP: begin
                out_d.res  = '0;
                out_d.flag = 1'b0;
            end
            default: begin
                out_d.res  = {{W{1'b0}}, bit_res};
                out_d.flag = bit_flag;
            end
        endcase
    end

    assign res_o  = out_d.res;
    assign cout_o = out_d.flag;

endmodule

// File: rtl/alu16_chk.sv
// Property checker bound to the ALU; each check is an algebraic inverse of its function.
module alu16_chk #(
    parameter int W = 16
) (
    input logic [W-1:0]   opa_i,
    input logic [W-1:0]   opb_i,
    input logic           cin_i,
    input logic [3:0]     sel_i,
    input logic [2*W-1:0] res_o,
    input logic           cout_o
);
    localparam int RW = 2 * W;

    logic [W-1:0]  lo;
    logic [W-1:0]  hi;
    logic [W-1:0]  c_w;
    logic [RW-1:0] a_x;
    logic [RW-1:0] b_x;
    logic [RW-1:0] qb;
    logic [W:0]    need;

    assign lo   = res_o[W-1:0];
    assign hi   = res_o[RW-1:W];
    assign c_w  = {{(W-1){1'b0}}, cin_i};
    assign a_x  = {{W{1'b0}}, opa_i};
    assign b_x  = {{W{1'b0}}, opb_i};
    assign qb   = {{W{1'b0}}, lo} * b_x;
    assign need = {1'b0, opb_i} + {{W{1'b0}}, cin_i};

    always_comb begin
        if (sel_i != 4'd2) begin
            // R10
            upper_zero_chk: assert (hi == '0)
                else $error("upper half not zero for code %0d", sel_i);
        end
        if (sel_i == 4'd0) begin
            // R1
            add_wrap_chk: assert (((lo - opb_i - c_w) == opa_i) &&
                                  (cout_o == (cin_i ? (lo <= opa_i) : (lo < opa_i))))
                else $error("add result or carry inconsistent");
        end
        if (sel_i == 4'd1) begin
            // R2
            sub_borrow_chk: assert (((lo + opb_i + c_w) == opa_i) &&
                                    (cout_o == ({1'b0, opa_i} < need)))
                else $error("subtract result or borrow inconsistent");
        end
        if (sel_i == 4'd2 && opb_i != '0) begin
            // R3
            mul_inverse_chk: assert (((res_o / b_x) == a_x) && ((res_o % b_x) == '0) && !cout_o)
                else $error("product does not divide back");
        end
        if (sel_i == 4'd3 && opb_i != '0) begin
            // R4
            div_bound_chk: assert ((qb <= a_x) && ((a_x - qb) < b_x) && !cout_o)
                else $error("quotient out of bounds");
        end
        if (sel_i == 4'd3 && opb_i == '0) begin
            // R5
            div_zero_chk: assert ((lo == '1) && cout_o)
                else $error("divide by zero not flagged");
        end
        if (sel_i == 4'd8) begin
            // R6
            nand_cover_chk: assert (((lo & opa_i & opb_i) == '0) &&
                                    ((lo | (opa_i & opb_i)) == '1) && !cout_o)
                else $error("nand result inconsistent");
        end
        if (sel_i == 4'd13) begin
            // R8
            rcl_link_chk: assert ((lo[0] == cin_i) && (cout_o == opa_i[W-1]) &&
                                  (lo[W-1:1] == opa_i[W-2:0]))
                else $error("left through-carry shift inconsistent");
        end
        if (sel_i == 4'd15) begin
            // R9
            nop_quiet_chk: assert ((res_o == '0) && !cout_o)
                else $error("no-operation code drove a value");
        end
    end

endmodule

bind alu16 alu16_chk #(.W(W)) u_alu16_chk (.*);

// File: tb/alu16_bench.sv
module alu16_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic        cin = 1'b0;
    logic [3:0]  sel = '0;
    logic [31:0] res;
    logic        cout;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;   // 125 MHz

    alu16 u_alu16 (
        .opa_i  (opa),
        .opb_i  (opb),
        .cin_i  (cin),
        .sel_i  (sel),
        .res_o  (res),
        .cout_o (cout)
    );

    // Reference model written from the requirements: {flag, result}.
    function automatic logic [32:0] golden(logic [3:0] s, logic [15:0] a, logic [15:0] b, logic c);
        logic [16:0] t;
        logic [31:0] r;
        logic        f;
        r = '0;
        f = 1'b0;
        case (s)
            4'd0:  begin t = {1'b0, a} + {1'b0, b} + {16'h0, c}; r = {16'h0, t[15:0]}; f = t[16]; end
            4'd1:  begin r = {16'h0, a - b - {15'h0, c}}; f = ({1'b0, a} < ({1'b0, b} + {16'h0, c})); end
            4'd2:  r = {16'h0, a} * {16'h0, b};
            4'd3:  begin
                       if (b == 16'h0) begin r = 32'h0000_FFFF; f = 1'b1; end
                       else r = {16'h0, a / b};
                   end
            4'd4:  r = {16'h0, a & b};
            4'd5:  r = {16'h0, a | b};
            4'd6:  r = {16'h0, ~a};
            4'd7:  r = {16'h0, a ^ b};
            4'd8:  r = {16'h0, ~(a & b)};
            4'd9:  r = {16'h0, ~(a | b)};
            4'd10: r = {16'h0, ~(a ^ b)};
            4'd11: r = {16'h0, a[14:0], 1'b0};
            4'd12: r = {17'h0, a[15:1]};
            4'd13: begin r = {16'h0, a[14:0], c}; f = a[15]; end
            4'd14: begin r = {16'h0, c, a[15:1]}; f = a[0]; end
            default: r = '0;
        endcase
        return {f, r};
    endfunction

    function automatic logic [31:0] next_rand(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic compare(string tag, logic [32:0] exp);
        vectors++;
        if ({cout, res} !== exp) begin
            miscompares++;
            $display("FAIL %s sel=%0d a=%h b=%h cin=%b: got flag=%b res=%h, expected flag=%b res=%h",
                     tag, sel, opa, opb, cin, cout, res, exp[32], exp[31:0]);
        end
    endtask

    task automatic apply(string tag, logic [3:0] s, logic [15:0] a, logic [15:0] b, logic c);
        @(negedge clk);
        sel = s; opa = a; opb = b; cin = c;
        #1;
        compare(tag, golden(s, a, b, c));
    endtask

    task automatic t_reset;
        @(negedge clk);
        #1;
        compare("R1 idle zero inputs", 33'h0);
    endtask

    task automatic t_arith;
        apply("R1 wrap", 4'd0, 16'hFFFF, 16'h0001, 1'b0);
        apply("R1 wrap cin", 4'd0, 16'hFFFF, 16'h0000, 1'b1);
        apply("R1 max", 4'd0, 16'hFFFF, 16'hFFFF, 1'b1);
        apply("R1 small", 4'd0, 16'h1234, 16'h4321, 1'b1);
        apply("R2 equal", 4'd1, 16'h0005, 16'h0005, 1'b0);
        apply("R2 equal cin", 4'd1, 16'h0005, 16'h0005, 1'b1);
        apply("R2 under", 4'd1, 16'h0000, 16'h0001, 1'b0);
        apply("R2 exact", 4'd1, 16'h0005, 16'h0004, 1'b1);
        for (int i = 0; i < 40; i++) begin
            seed = next_rand(seed);
            apply("R1 random", 4'd0, seed[15:0], seed[31:16], seed[3]);
            apply("R2 random", 4'd1, seed[31:16], seed[15:0], seed[7]);
        end
    endtask

    task automatic t_muldiv;
        apply("R3 max", 4'd2, 16'hFFFF, 16'hFFFF, 1'b0);
        apply("R3 zero", 4'd2, 16'h1234, 16'h0000, 1'b0);
        apply("R3 top", 4'd2, 16'h8000, 16'h0002, 1'b0);
        apply("R4 one", 4'd3, 16'hABCD, 16'h0001, 1'b0);
        apply("R4 big divisor", 4'd3, 16'h0007, 16'h0009, 1'b0);
        apply("R4 equal", 4'd3, 16'h4242, 16'h4242, 1'b0);
        apply("R4 max", 4'd3, 16'hFFFF, 16'h0003, 1'b0);
        apply("R5 zero div", 4'd3, 16'h1357, 16'h0000, 1'b0);
        apply("R5 zero by zero", 4'd3, 16'h0000, 16'h0000, 1'b0);
        for (int i = 0; i < 40; i++) begin
            seed = next_rand(seed);
            apply("R3 random", 4'd2, seed[15:0], seed[31:16], 1'b0);
            apply("R4 random", 4'd3, seed[31:16], {8'h0, seed[7:0]} | 16'h0001, 1'b0);
        end
    endtask

    task automatic t_logic;
        for (int s = 4; s <= 10; s++) begin
            apply("R6 pattern", 4'(s), 16'hF0F0, 16'hFF00, 1'b0);
            apply("R6 ones", 4'(s), 16'hFFFF, 16'h0000, 1'b0);
            for (int i = 0; i < 6; i++) begin
                seed = next_rand(seed);
                apply("R6 random", 4'(s), seed[15:0], seed[31:16], 1'b0);
            end
        end
    endtask

    task automatic t_shift;
        apply("R7 left top", 4'd11, 16'h8001, 16'h0000, 1'b0);
        apply("R7 right bottom", 4'd12, 16'h8001, 16'h0000, 1'b0);
        apply("R8 rcl carry", 4'd13, 16'h8000, 16'h0000, 1'b1);
        apply("R8 rcl none", 4'd13, 16'h4001, 16'h0000, 1'b0);
        apply("R8 rcr carry", 4'd14, 16'h0001, 16'h0000, 1'b1);
        apply("R8 rcr none", 4'd14, 16'h8002, 16'h0000, 1'b0);
        for (int i = 0; i < 20; i++) begin
            seed = next_rand(seed);
            apply("R7 random", 4'(11 + (i % 2)), seed[15:0], seed[31:16], 1'b0);
            apply("R8 random", 4'(13 + (i % 2)), seed[15:0], seed[31:16], seed[9]);
        end
    endtask

    task automatic t_nop;
        apply("R9 ones", 4'd15, 16'hFFFF, 16'hFFFF, 1'b1);
        apply("R9 mixed", 4'd15, 16'h1234, 16'h00FF, 1'b0);
    endtask

    task automatic t_upper;
        for (int s = 0; s < 16; s++) begin
            apply("R10 upper half", 4'(s), 16'hFFFF, 16'hFFFF, 1'b1);
        end
    endtask

    task automatic t_comb;
        @(negedge clk);
        sel = 4'd0; opa = 16'h0100; opb = 16'h0010; cin = 1'b0;
        #1;
        compare("R11 first code", golden(4'd0, 16'h0100, 16'h0010, 1'b0));
        sel = 4'd1;   // no clock edge between
        #1;
        compare("R11 code change", golden(4'd1, 16'h0100, 16'h0010, 1'b0));
        sel = 4'd2;
        #1;
        compare("R11 code change", golden(4'd2, 16'h0100, 16'h0010, 1'b0));
    endtask

    task automatic t_cin;
        logic [32:0] base;
        for (int s = 2; s <= 15; s++) begin
            if (s == 13 || s == 14) continue;
            seed = next_rand(seed);
            apply("R12 cin low", 4'(s), seed[15:0], seed[31:16] | 16'h0001, 1'b0);
            base = {cout, res};
            @(negedge clk);
            cin = 1'b1;
            #1;
            compare("R12 cin high", base);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_arith();
        t_muldiv();
        t_logic();
        t_shift();
        t_nop();
        t_upper();
        t_comb();
        t_cin();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete, got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule